// File: doc/BRIEF.md
# Cascadable Priority Interrupt Controller

The block gathers eight interrupt request inputs, ranks them under a rotatable priority order, and raises one interrupt line toward a processor. The processor answers with a two-pulse acknowledge. On the first pulse the winning request moves into the in-service register. On the second pulse the block returns an 8-bit vector made from a programmed base and the input number. Software reaches the block through a byte-wide port with two addresses. A write to address 0 that carries the initialise bit starts a short configuration sequence. Once that sequence is complete, address 1 holds the interrupt mask and address 0 takes commands: end-of-interrupt, set-lowest-priority and read-select.

Two controllers can be chained. A master is told which of its inputs carry a slave. When it acknowledges such an input it stays off the vector and names the input on its cascade output. A slave compares that cascade code with its own 3-bit identity and answers only when the two match. An acknowledge that finds no eligible request returns the vector of input 7 and sets no in-service bit, so software can recognise it as spurious.

Two enumerated state machines carry the behaviour.

The configuration sequencer has four states:
- `SEQ_READY`: normal operation.
- `SEQ_VBASE`: waiting for the vector base.
- `SEQ_CASC`: waiting for the cascade word.
- `SEQ_MODE`: waiting for the mode word.

Its transitions are:
- `start_init`: from any state to `SEQ_VBASE`, on an initialise write.
- `take_vbase`: `SEQ_VBASE` to `SEQ_CASC`, on an address-1 write.
- `take_casc`: `SEQ_CASC` to `SEQ_MODE` when a mode word was announced, otherwise to `SEQ_READY`, on an address-1 write.
- `take_mode`: `SEQ_MODE` to `SEQ_READY`, on an address-1 write.

The acknowledge tracker has two states:
- `ACK_IDLE`: no acknowledge in progress.
- `ACK_HELD`: between the two pulses.

Its transitions are:
- `first_pulse`: `ACK_IDLE` to `ACK_HELD`.
- `second_pulse`: `ACK_HELD` to `ACK_IDLE`.
- `start_init`: either state to `ACK_IDLE`.

Top module: `pic_ctrl`

## Requirements
- R1: After reset, int_out is low. A read of address 1 returns 0xFF, meaning every input is masked. A read of address 0 returns 0x00, and reads of address 0 return the request register.
- R2: Writing address 0 with bit 4 set starts initialisation. In that first word, bit 0 announces a mode word and bit 3 selects level sensing. The following address-1 writes are taken in this order:
  - the vector base;
  - the cascade word;
  - the mode word, only when bit 0 of the first word was set.

  The address-1 write after that sets the mask. Initialisation clears the request and in-service registers and sets the lowest priority to 7. If no mode word follows, the block uses non-8086 mode without automatic end-of-interrupt and acts as a master.
- R3: Outside initialisation, an address-1 write sets the mask and an address-1 read returns it. A mask bit of 1 keeps that input from raising int_out and from being acknowledged. A masked request still shows in the request register.
- R4: In edge mode, a request bit is set on a rising input and stays set until it is acknowledged, even if the input falls first. In level mode, each request bit follows its input level.
- R5: Priority is rotating. Writing 0xC0|L to address 0 makes input L the lowest priority, and the order runs from L+1 upward, wrapping through 7 and 0 back to L. After initialisation, input 0 is highest and input 7 is lowest.
- R6: On the first acknowledge pulse, the winning request is set in the in-service register and, in edge mode, cleared from the request register. During the second pulse, vec_valid is high and vec_out carries the vector:
  - when mode word bit 0 (8086 mode) is 1: {base[7:3], input};
  - otherwise: base + input, as an 8-bit sum.
- R7: A request is eligible only when it ranks strictly above the highest-priority set in-service bit. A request of equal or lower priority does not raise int_out.
- R8: Writing 0x20 to address 0 (non-specific end-of-interrupt) clears the highest-priority set in-service bit.
- R9: When mode word bit 1 (automatic end-of-interrupt) is 1, the second acknowledge pulse clears the in-service bit that the first pulse set.
- R10: Writing 0x0B to address 0 makes address-0 reads return the in-service register. Writing 0x0A selects the request register. The choice persists until the next such command, and initialisation resets it to the request register.
- R11: If no eligible request exists at the first acknowledge pulse, the vector for input 7 is returned and the in-service register is left unchanged.
- R12: Mode word bit 2 selects the role: 1 is master, 0 is slave.
  - A master acknowledging an input whose bit is set in the cascade word keeps vec_valid low and drives that input number on cas_out.
  - A slave takes the cascade word's bits 2:0 as its identity. It latches and answers an acknowledge only when cas_in equals that identity at the first pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe, one cycle per byte |
| bus_addr | input | 1 | Register address (0 or 1) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the current address |
| irq_in | input | 8 | Interrupt request inputs |
| int_out | output | 1 | Interrupt request to the processor |
| inta | input | 1 | Acknowledge pulse, one cycle per pulse, two pulses per acknowledge |
| vec_out | output | 8 | Vector, valid while vec_valid is high |
| vec_valid | output | 1 | Block drives the vector during the second pulse |
| cas_in | input | 3 | Cascade code seen by a slave |
| cas_out | output | 3 | Cascade code driven by a master |

## Verification
The hardest situation to reach is an acknowledge that races the request register. It covers two cases: a request that vanishes, or is masked, before the first pulse, and a new request that must wait behind a higher in-service level until an end-of-interrupt releases it. The stimulus reaches the first case in level mode by dropping the input just before acknowledging. It reaches the second by stacking edge requests of mixed priority, then issuing end-of-interrupt commands one at a time and reading the in-service register after each. Randomised rounds with random masks, request sets and lowest-priority levels test the rotating resolver against a model of the priority order.

// File: rtl/pic_ctrl_pkg.sv
package pic_ctrl_pkg;
    localparam int DATA_W  = 8;
    localparam int NUM_IRQ = 8;
    localparam int IDX_W   = $clog2(NUM_IRQ);

    typedef enum logic [1:0] {
        SEQ_READY,
        SEQ_VBASE,
        SEQ_CASC,
        SEQ_MODE
    } seq_state_t;

    typedef enum logic {
        ACK_IDLE,
        ACK_HELD
    } ack_state_t;

    // command field values on address 0
    localparam logic [2:0] OP_NS_EOI  = 3'b001;
    localparam logic [2:0] OP_SET_LOW = 3'b110;
endpackage

// File: rtl/pic_cfg_seq.sv
module pic_cfg_seq
    import pic_ctrl_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int IW = IDX_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_wr,
    input  logic          bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic          init_pulse,
    output logic          eoi_pulse,
    output logic          seq_ready,
    output logic [DW-1:0] mask,
    output logic [DW-1:0] vbase,
    output logic [DW-1:0] casc,
    output logic          mode_x86,
    output logic          mode_aeoi,
    output logic          mode_master,
    output logic          level_mode,
    output logic          rd_isr,
    output logic [IW-1:0] low_lvl
);
    seq_state_t st_q, st_n;
    logic       need_mode;
    logic       wr0, wr1, cmd_sel, op_word;

    assign wr0        = bus_wr & ~bus_addr;
    assign wr1        = bus_wr & bus_addr;
    assign init_pulse = wr0 & bus_wdata[4];
    assign seq_ready  = (st_q == SEQ_READY);
    assign cmd_sel    = wr0 & ~bus_wdata[4] & bus_wdata[3] & seq_ready;
    assign op_word    = wr0 & ~bus_wdata[4] & ~bus_wdata[3] & seq_ready;
    assign eoi_pulse  = op_word & (bus_wdata[7:5] == OP_NS_EOI);

    always_comb begin
        st_n = st_q;
        if (init_pulse) begin
            st_n = SEQ_VBASE;
        end else if (wr1) begin
            unique case (st_q)
                SEQ_READY: st_n = SEQ_READY;
                SEQ_VBASE: st_n = SEQ_CASC;
                SEQ_CASC:  st_n = need_mode ? SEQ_MODE : SEQ_READY;
                SEQ_MODE:  st_n = SEQ_READY;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= SEQ_READY;
        else        st_q <= st_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask        <= '1;
            vbase       <= '0;
            casc        <= '0;
            need_mode   <= 1'b0;
            mode_x86    <= 1'b0;
            mode_aeoi   <= 1'b0;
            mode_master <= 1'b1;
            level_mode  <= 1'b0;
            rd_isr      <= 1'b0;
            low_lvl     <= '1;
        end else if (init_pulse) begin
            need_mode   <= bus_wdata[0];
            level_mode  <= bus_wdata[3];
            mode_x86    <= 1'b0;
            mode_aeoi   <= 1'b0;
            mode_master <= 1'b1;
            rd_isr      <= 1'b0;
            low_lvl     <= '1;
        end else begin
            if (wr1) begin
                unique case (st_q)
                    SEQ_READY: mask  <= bus_wdata;
                    SEQ_VBASE: vbase <= bus_wdata;
                    SEQ_CASC:  casc  <= bus_wdata;
                    SEQ_MODE: begin
                        mode_x86    <= bus_wdata[0];
                        mode_aeoi   <= bus_wdata[1];
                        mode_master <= bus_wdata[2];
                    end
                endcase
            end
            if (cmd_sel && bus_wdata[1])
                rd_isr <= bus_wdata[0];
            if (op_word && bus_wdata[7:5] == OP_SET_LOW)
                low_lvl <= bus_wdata[IW-1:0];
        end
    end
endmodule

// File: rtl/pic_resolver.sv
module pic_resolver
    import pic_ctrl_pkg::*;
#(
    parameter int N  = NUM_IRQ,
    parameter int IW = IDX_W
) (
    input  logic [N-1:0]  req_vec,
    input  logic [N-1:0]  isr_vec,
    input  logic [IW-1:0] low_lvl,
    output logic          req_any,
    output logic [IW-1:0] req_idx,
    output logic          isr_any,
    output logic [IW-1:0] isr_idx,
    output logic          grant_ok
);
    logic [IW-1:0] req_rank, isr_rank;

    // scan from lowest to highest priority so the last hit wins
    always_comb begin
        req_any = 1'b0;
        req_idx = '0;
        isr_any = 1'b0;
        isr_idx = '0;
        for (int k = N - 1; k >= 0; k--) begin
            logic [IW-1:0] idx;
            idx = IW'(int'(low_lvl) + 1 + k);
            if (req_vec[idx]) begin
                req_any = 1'b1;
                req_idx = idx;
            end
            if (isr_vec[idx]) begin
                isr_any = 1'b1;
                isr_idx = idx;
            end
        end
    end

    assign req_rank = IW'(req_idx - low_lvl - IW'(1));
    assign isr_rank = IW'(isr_idx - low_lvl - IW'(1));
    assign grant_ok = req_any & (~isr_any | (req_rank < isr_rank));
endmodule

// File: rtl/pic_irq_core.sv
module pic_irq_core
    import pic_ctrl_pkg::*;
#(
    parameter int N  = NUM_IRQ,
    parameter int DW = DATA_W,
    parameter int IW = IDX_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  irq_in,
    input  logic          inta,
    input  logic          init_pulse,
    input  logic          eoi_pulse,
    input  logic          level_mode,
    input  logic [N-1:0]  mask,
    input  logic [IW-1:0] low_lvl,
    input  logic [DW-1:0] vbase,
    input  logic [DW-1:0] casc,
    input  logic          mode_x86,
    input  logic          mode_aeoi,
    input  logic          mode_master,
    input  logic [IW-1:0] cas_in,
    output logic          int_out,
    output logic [DW-1:0] vec_out,
    output logic          vec_valid,
    output logic [IW-1:0] cas_out,
    output logic [N-1:0]  irr,
    output logic [N-1:0]  isr,
    output logic          ack_idle
);
    ack_state_t    st_q, st_n;
    logic [N-1:0]  irq_prev, edge_q, edge_n, isr_n;
    logic [IW-1:0] held_idx, req_idx, isr_idx, ack_idx;
    logic          held_spur, held_drv;
    logic          req_any, isr_any, grant_ok, sel_ok, first_p, second_p;

    assign irr = level_mode ? irq_in : edge_q;

    pic_resolver #(.N(N), .IW(IW)) u_res (
        .req_vec (irr & ~mask),
        .isr_vec (isr),
        .low_lvl (low_lvl),
        .req_any (req_any),
        .req_idx (req_idx),
        .isr_any (isr_any),
        .isr_idx (isr_idx),
        .grant_ok(grant_ok)
    );

    assign sel_ok   = mode_master | (cas_in == casc[IW-1:0]);
    assign ack_idle = (st_q == ACK_IDLE);
    assign first_p  = inta & (st_q == ACK_IDLE);
    assign second_p = inta & (st_q == ACK_HELD);

    always_comb begin
        st_n = st_q;
        unique case (st_q)
            ACK_IDLE: if (inta) st_n = ACK_HELD;
            ACK_HELD: if (inta) st_n = ACK_IDLE;
        endcase
        if (init_pulse) st_n = ACK_IDLE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ACK_IDLE;
        else        st_q <= st_n;
    end

    always_comb begin
        edge_n = edge_q | (irq_in & ~irq_prev);
        isr_n  = isr;
        if (init_pulse) begin
            edge_n = '0;
            isr_n  = '0;
        end else begin
            if (eoi_pulse && isr_any)
                isr_n[isr_idx] = 1'b0;
            if (first_p && grant_ok && sel_ok) begin
                isr_n[req_idx]  = 1'b1;
                edge_n[req_idx] = 1'b0;
            end
            if (second_p && mode_aeoi && held_drv && !held_spur)
                isr_n[held_idx] = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_prev  <= '0;
            edge_q    <= '0;
            isr       <= '0;
            held_idx  <= '0;
            held_spur <= 1'b0;
            held_drv  <= 1'b0;
        end else begin
            irq_prev <= irq_in;
            edge_q   <= edge_n;
            isr      <= isr_n;
            if (first_p) begin
                held_idx  <= req_idx;
                held_spur <= ~grant_ok;
                held_drv  <= sel_ok;
            end
        end
    end

    always_comb begin
        ack_idx   = held_spur ? IW'(N - 1) : held_idx;
        vec_out   = mode_x86 ? {vbase[DW-1:IW], ack_idx} : DW'(vbase + DW'(ack_idx));
        vec_valid = second_p & held_drv & ~(mode_master & casc[held_idx] & ~held_spur);
        cas_out   = (st_q == ACK_HELD) ? held_idx : req_idx;
        int_out   = grant_ok;
    end
endmodule

// File: rtl/pic_ctrl.sv
module pic_ctrl
    import pic_ctrl_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int N  = NUM_IRQ,
    parameter int IW = IDX_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_wr,
    input  logic          bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    input  logic [N-1:0]  irq_in,
    output logic          int_out,
    input  logic          inta,
    output logic [DW-1:0] vec_out,
    output logic          vec_valid,
    input  logic [IW-1:0] cas_in,
    output logic [IW-1:0] cas_out
);
    logic          init_pulse, eoi_pulse, seq_ready;
    logic [DW-1:0] mask_w, vbase_w, casc_w;
    logic          x86_w, aeoi_w, master_w, level_w, rd_isr_w, ack_idle_w;
    logic [IW-1:0] low_w;
    logic [N-1:0]  irr_w, isr_w;

    pic_cfg_seq #(.DW(DW), .IW(IW)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_wr     (bus_wr),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .init_pulse (init_pulse),
        .eoi_pulse  (eoi_pulse),
        .seq_ready  (seq_ready),
        .mask       (mask_w),
        .vbase      (vbase_w),
        .casc       (casc_w),
        .mode_x86   (x86_w),
        .mode_aeoi  (aeoi_w),
        .mode_master(master_w),
        .level_mode (level_w),
        .rd_isr     (rd_isr_w),
        .low_lvl    (low_w)
    );

    pic_irq_core #(.N(N), .DW(DW), .IW(IW)) u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .irq_in     (irq_in),
        .inta       (inta),
        .init_pulse (init_pulse),
        .eoi_pulse  (eoi_pulse),
        .level_mode (level_w),
        .mask       (mask_w[N-1:0]),
        .low_lvl    (low_w),
        .vbase      (vbase_w),
        .casc       (casc_w),
        .mode_x86   (x86_w),
        .mode_aeoi  (aeoi_w),
        .mode_master(master_w),
        .cas_in     (cas_in),
        .int_out    (int_out),
        .vec_out    (vec_out),
        .vec_valid  (vec_valid),
        .cas_out    (cas_out),
        .irr        (irr_w),
        .isr        (isr_w),
        .ack_idle   (ack_idle_w)
    );

    assign bus_rdata = bus_addr ? mask_w : DW'(rd_isr_w ? isr_w : irr_w);
endmodule

// File: rtl/pic_ctrl_chk.sv
module pic_ctrl_chk #(
    parameter int DW = 8,
    parameter int N  = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          bus_wr,
    input logic          bus_addr,
    input logic [DW-1:0] bus_wdata,
    input logic          inta,
    input logic          int_out,
    input logic          vec_valid,
    input logic [N-1:0]  irr,
    input logic [N-1:0]  isr,
    input logic [DW-1:0] mask,
    input logic          ack_idle,
    input logic          seq_ready,
    input logic          eoi_pulse,
    input logic          init_pulse,
    input logic          master
);
    p_vec_needs_ack_r6: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |-> inta);

    p_first_ack_sets_isr_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (inta && ack_idle && int_out && master && !eoi_pulse && !init_pulse)
        |=> ($countones(isr) == $countones($past(isr)) + 1));

    p_eoi_clears_one_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_pulse && isr != '0 && !inta && !init_pulse)
        |=> ($countones(isr) + 1 == $countones($past(isr))));

    p_int_needs_unmasked_r3: assert property (@(posedge clk) disable iff (!rst_n)
        int_out |-> ((irr & ~mask[N-1:0]) != '0));

    p_mask_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr && seq_ready && !init_pulse) |=> (mask == $past(bus_wdata)));

    p_spur_keeps_isr_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (inta && ack_idle && !int_out && !eoi_pulse && !init_pulse) |=> (isr == $past(isr)));
endmodule

bind pic_ctrl pic_ctrl_chk #(.DW(DW), .N(N)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .inta      (inta),
    .int_out   (int_out),
    .vec_valid (vec_valid),
    .irr       (irr_w),
    .isr       (isr_w),
    .mask      (mask_w),
    .ack_idle  (ack_idle_w),
    .seq_ready (seq_ready),
    .eoi_pulse (eoi_pulse),
    .init_pulse(init_pulse),
    .master    (master_w)
);

// File: tb/pic_ctrl_tb_top.sv
`timescale 1ns/1ps
module pic_ctrl_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0;
    logic       bus_addr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [7:0] irq_in = '0;
    logic       int_out;
    logic       inta = 1'b0;
    logic [7:0] vec_out;
    logic       vec_valid;
    logic [2:0] cas_in = '0;
    logic [2:0] cas_out;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    pic_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_in(irq_in),
        .int_out(int_out), .inta(inta), .vec_out(vec_out),
        .vec_valid(vec_valid), .cas_in(cas_in), .cas_out(cas_out)
    );

    task automatic check(input string tag, input int got, input int exp);
        n_chk++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic set_irq(input logic [7:0] v);
        @(negedge clk);
        irq_in = v;
        @(negedge clk);
    endtask

    task automatic ack(output logic valid, output logic [7:0] vec, output logic [2:0] cas);
        @(negedge clk);
        inta = 1'b1;
        @(negedge clk);
        inta = 1'b0;
        @(negedge clk);
        inta = 1'b1;
        #1;
        valid = vec_valid; vec = vec_out; cas = cas_out;
        @(negedge clk);
        inta = 1'b0;
    endtask

    function automatic int winner(input logic [7:0] req, input logic [2:0] low);
        for (int k = 1; k <= 8; k++) begin
            int idx;
            idx = (int'(low) + k) % 8;
            if (req[idx]) return idx;
        end
        return -1;
    endfunction

    task automatic init4(input logic [7:0] w1, input logic [7:0] b, input logic [7:0] c, input logic [7:0] m);
        wr(0, w1); wr(1, b); wr(1, c);
        if (w1[0]) wr(1, m);
    endtask

    initial begin
        logic [7:0] d, v;
        logic       vl;
        logic [2:0] cs;
        void'($urandom(32'h5eed_1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 int_out", int_out, 0);
        rd(1, d); check("R1 mask", d, 8'hFF);
        rd(0, d); check("R1 irr", d, 8'h00);

        // R2 init, edge, master, 8086, slave on input 2
        init4(8'h11, 8'h20, 8'h04, 8'h05);
        wr(1, 8'hF0);
        rd(1, d); check("R2 mask after init", d, 8'hF0);

        // R3 masked request shows in IRR but no int
        set_irq(8'h20);
        check("R3 masked no int", int_out, 0);
        rd(0, d); check("R3 masked in irr", d, 8'h20);
        set_irq(8'h28);
        check("R3 unmasked int", int_out, 1);
        ack(vl, v, cs);
        check("R6 valid", vl, 1); check("R6 vector 8086", v, 8'h23);
        rd(0, d); check("R6 irr cleared", d, 8'h20);
        wr(0, 8'h0B);
        rd(0, d); check("R10 isr select", d, 8'h08);
        rd(0, d); check("R10 persists", d, 8'h08);
        wr(1, 8'h00);
        check("R7 lower blocked", int_out, 0);
        set_irq(8'h2A);
        check("R7 higher passes", int_out, 1);
        ack(vl, v, cs); check("R6 vector in1", v, 8'h21);
        rd(0, d); check("R7 nested isr", d, 8'h0A);
        wr(0, 8'h20);
        rd(0, d); check("R8 eoi clears top", d, 8'h08);
        check("R7 still blocked", int_out, 0);
        wr(0, 8'h20);
        rd(0, d); check("R8 eoi second", d, 8'h00);
        check("R7 released", int_out, 1);
        ack(vl, v, cs); check("R6 vector in5", v, 8'h25);
        wr(0, 8'h20);
        set_irq(8'h00);

        // R4 edge sticky
        set_irq(8'h40); set_irq(8'h00);
        wr(0, 8'h0A);
        rd(0, d); check("R4 edge sticky", d, 8'h40);
        ack(vl, v, cs); check("R4 vector in6", v, 8'h26);
        wr(0, 8'h20);

        // R12 master cascade input
        set_irq(8'h04);
        check("R12 int from slave line", int_out, 1);
        ack(vl, v, cs);
        check("R12 master silent", vl, 0); check("R12 cas code", cs, 2);
        wr(0, 8'h20); set_irq(8'h00);

        // level, AEOI, master, base 0x40
        set_irq(8'h10);
        init4(8'h19, 8'h40, 8'h00, 8'h07);
        wr(1, 8'h00);
        rd(0, d); check("R10 default irr", d, 8'h10);
        check("R4 level int", int_out, 1);
        set_irq(8'h00);
        check("R4 level follows", int_out, 0);
        ack(vl, v, cs);
        check("R11 spur valid", vl, 1); check("R11 spur vector", v, 8'h47);
        wr(0, 8'h0B);
        rd(0, d); check("R11 isr untouched", d, 8'h00);
        set_irq(8'h08);
        ack(vl, v, cs); check("R9 vector", v, 8'h43);
        rd(0, d); check("R9 aeoi isr clear", d, 8'h00);
        set_irq(8'h00);

        // R5 rotation
        wr(0, 8'hC2);
        set_irq(8'h47);
        ack(vl, v, cs); check("R5 low2 winner", v, 8'h46);
        wr(0, 8'hC6);
        ack(vl, v, cs); check("R5 low6 winner", v, 8'h40);
        set_irq(8'h00);

        // R6 non-8086 vector
        init4(8'h11, 8'h3C, 8'h00, 8'h04);
        wr(1, 8'h00);
        set_irq(8'h20);
        ack(vl, v, cs); check("R6 non8086 sum", v, 8'h41);
        set_irq(8'h00);

        // R12 slave id 3
        init4(8'h11, 8'h80, 8'h03, 8'h01);
        wr(1, 8'h00);
        set_irq(8'h02);
        cas_in = 3'd2;
        ack(vl, v, cs); check("R12 slave not selected", vl, 0);
        wr(0, 8'h0B);
        rd(0, d); check("R12 slave isr empty", d, 8'h00);
        cas_in = 3'd3;
        ack(vl, v, cs);
        check("R12 slave selected", vl, 1); check("R12 slave vector", v, 8'h81);
        set_irq(8'h00); cas_in = 3'd0;

        // random rounds: R5 R3 R6
        for (int r = 0; r < 24; r++) begin
            logic [7:0] m, req, base;
            logic [2:0] low;
            int w;
            m = 8'($urandom); req = 8'($urandom);
            base = 8'($urandom) & 8'hF8; low = 3'($urandom);
            init4(8'h11, base, 8'h00, 8'h01);
            wr(1, m);
            wr(0, 8'hC0 | 8'(low));
            set_irq(req); set_irq(8'h00);
            w = winner(req & ~m, low);
            check("R5 random int", int_out, (w >= 0) ? 1 : 0);
            if (w >= 0) begin
                ack(vl, v, cs);
                check("R5 random vector", v, int'(base) + w);
                wr(0, 8'h0B);
                rd(0, d); check("R6 random isr", d, 1 << w);
            end
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule